// File: doc/BRIEF.md
# Multi-Register Memory Transfer Sequencer

This block moves any chosen subset of sixteen 32-bit registers between a register file and consecutive memory locations. Registers 0 to 7 are the data registers and registers 8 to 15 are the address registers. A 16-bit select mask picks the registers. Each register moves as one word, or as one longword built from two 16-bit bus cycles. The surrounding execution unit provides a start address, a direction, a size and an addressing mode, then pulses `start`. The sequencer walks the mask and issues one memory request per 16-bit word. It reads or writes the register file, and on completion it reports the address that belongs in the base register.

Three addressing modes are supported. The predecrement mode pushes registers onto a stack that grows downward. The postincrement mode pops them back. The plain mode gives a fixed block move that has no base writeback. A word-size load is always sign-extended, for address registers as well as for data registers. An empty mask touches neither memory nor any register. It still takes one idle cycle, which stands in for the extension-word fetch, and then signals completion. The sequencer has no condition-flag output, so a transfer never changes the flags.

Top module: `regset_xfer`

## Requirements
- R1: Only registers whose select bit is set take part. A store writes no register. A load writes only the selected registers, and all other registers and memory words keep their values.
- R2: `long_sz`=1 moves 32 bits per register in two bus cycles: the high half goes at the lower address and is transferred first, and the low half goes 2 bytes above it. `long_sz`=0 moves the low 16 bits in one cycle. Every bus address is even and stays stable until acknowledged.
- R3: Every word load is sign-extended from bit 15 into bits 31:16, for registers 0 to 15 alike. For example, memory word 0xABAB loads as 0xFFFFABAB.
- R4: In `mode`=2'd0 (plain) and `mode`=2'd2 (postincrement), mask bit k selects register k. Registers are visited in increasing k, and the n-th selected register (counting from 0) sits at base + n*S, with S = 2 for word and 4 for long.
- R5: In `mode`=2'd1 (predecrement), mask bit k selects register 15-k. Registers are visited from 15 down to 0, and the n-th selected register (counting from 0) sits at base - (n+1)*S, so that register 15 ends up highest in memory.
- R6: When `done` is high, `final_addr` equals base - N*S in predecrement mode and base + N*S in postincrement mode, where N is the number of selected registers. `wb_en` is high with `done` only in those two modes and only for a non-empty mask. Plain mode never raises `wb_en`.
- R7: `done` is a one-cycle pulse. It appears in the cycle right after the clock edge that takes the last bus acknowledge.
- R8: An all-zero mask issues no bus request, writes no register and keeps `wb_en` low. `done` appears in the second cycle after the `start` edge.
- R9: A `start` pulse while `busy` is high is ignored. The running transfer ends exactly as if that pulse had not occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| mask | input | 16 | Register select bits |
| to_regs | input | 1 | 1 = memory to registers, 0 = registers to memory |
| long_sz | input | 1 | 1 = 32-bit per register, 0 = 16-bit |
| mode | input | 2 | 0 plain, 1 predecrement, 2 postincrement (3 acts as plain) |
| base_addr | input | AW | Start address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| wb_en | output | 1 | Write `final_addr` back to the base register |
| final_addr | output | AW | Updated base address |
| rf_raddr | output | 4 | Register file read index (asynchronous read) |
| rf_rdata | input | 32 | Register file read data |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Byte address of the 16-bit word |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Load data |
| mem_ack | input | 1 | Memory acknowledge, completes the current word |

## Verification
The sweep covers every combination of direction, size and mode against twelve masks. These include the empty mask, the single lowest and single highest bit, the full mask, both byte halves and both alternating patterns, plus LFSR-derived masks. Single-bit and half masks show whether the predecrement bit reversal and the visiting order are right. Alternating masks catch address steps that skip or double-count deselected registers. A load of 0xABAB words into all sixteen registers separates sign extension from zero extension in the address registers. A second `start` pulse issued in the middle of a transfer, with a different mask and mode, shows whether a busy sequencer is disturbed.

// File: rtl/regset_xfer.sv
module regset_xfer #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   mask,
  input  logic          to_regs,
  input  logic          long_sz,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] base_addr,
  output logic          busy,
  output logic          done,
  output logic          wb_en,
  output logic [AW-1:0] final_addr,
  output logic [3:0]    rf_raddr,
  input  logic [31:0]   rf_rdata,
  output logic          rf_we,
  output logic [3:0]    rf_waddr,
  output logic [31:0]   rf_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  input  logic          mem_ack
);
  localparam logic [1:0] M_PRE  = 2'd1;
  localparam logic [1:0] M_POST = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_EMPTY, S_BUS, S_DONE} st_t;

  st_t           st;
  logic [15:0]   rem;
  logic [AW-1:0] addr, fin;
  logic [15:0]   hold;
  logic          half, r_load, r_long, r_pre, r_post, r_empty;

  function automatic logic [3:0] low_idx(input logic [15:0] v);
    low_idx = '0;
    for (int i = 15; i >= 0; i--)
      if (v[i]) low_idx = 4'(i);
  endfunction

  logic [3:0]    idx, reg_id;
  logic          last_word, take;
  logic [15:0]   rem_next;
  logic [4:0]    cnt;
  logic [AW-1:0] sz, span;

  assign idx       = low_idx(rem);
  assign reg_id    = r_pre ? ~idx : idx;
  assign last_word = !r_long || half;
  assign rem_next  = rem & ~(16'b1 << idx);
  assign take      = (st == S_IDLE) && start;
  assign cnt       = 5'($countones(mask));
  assign sz        = long_sz ? AW'(4) : AW'(2);
  assign span      = AW'(cnt) << (long_sz ? 2 : 1);

  assign busy       = st != S_IDLE;
  assign done       = st == S_DONE;
  assign wb_en      = done && !r_empty && (r_pre || r_post);
  assign final_addr = fin;

  assign mem_req   = st == S_BUS;
  assign mem_we    = !r_load;
  assign mem_addr  = addr;
  assign mem_wdata = (r_long && !half) ? rf_rdata[31:16] : rf_rdata[15:0];

  assign rf_raddr = reg_id;
  assign rf_waddr = reg_id;
  assign rf_we    = mem_req && r_load && mem_ack && last_word;
  assign rf_wdata = r_long ? {hold, mem_rdata} : {{16{mem_rdata[15]}}, mem_rdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      rem <= '0;
      addr <= '0;
      fin <= '0;
      hold <= '0;
      half <= 1'b0;
      r_load <= 1'b0;
      r_long <= 1'b0;
      r_pre <= 1'b0;
      r_post <= 1'b0;
      r_empty <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (take) begin
          r_load  <= to_regs;
          r_long  <= long_sz;
          r_pre   <= mode == M_PRE;
          r_post  <= mode == M_POST;
          r_empty <= mask == 16'h0;
          rem     <= mask;
          half    <= 1'b0;
          addr    <= (mode == M_PRE) ? base_addr - sz : base_addr;
          fin     <= (mode == M_PRE) ? base_addr - span : base_addr + span;
          st      <= (mask == 16'h0) ? S_EMPTY : S_BUS;
        end
        S_EMPTY: st <= S_DONE;
        S_BUS: if (mem_ack) begin
          if (!last_word) begin
            half <= 1'b1;
            hold <= mem_rdata;
            addr <= addr + AW'(2);
          end else begin
            half <= 1'b0;
            rem  <= rem_next;
            addr <= r_pre ? addr - (r_long ? AW'(6) : AW'(2)) : addr + AW'(2);
            if (rem_next == 16'h0) st <= S_DONE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_addr_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[0] == 1'b0);
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  p_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && !r_long |-> rf_wdata[31:16] == {16{rf_wdata[15]}});
  p_store_no_rf_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !rf_we);
  p_wb_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !r_empty |-> $past(mem_req && mem_ack));
  p_empty_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && mask == 16'h0 |=> !mem_req && !rf_we ##1 done && !wb_en);
  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !done |=> $stable(final_addr));
endmodule

// File: tb/test_regset_xfer.sv
`timescale 1ns/1ps
module test_regset_xfer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, to_regs = 1'b0, long_sz = 1'b0;
  logic [15:0] mask = '0;
  logic [1:0]  mode = '0;
  logic [31:0] base_addr = '0;
  logic busy, done, wb_en, rf_we, mem_req, mem_we;
  logic [31:0] final_addr, rf_rdata, rf_wdata, mem_addr;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [15:0] mem_wdata, mem_rdata;
  logic mem_ack = 1'b0;

  logic [31:0] rf [16];
  logic [15:0] mem [128];
  logic [31:0] exp_rf [16];
  logic [15:0] exp_mem [128];
  int checks = 0, failures = 0, n_acks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  regset_xfer #(.AW(32)) i_regset_xfer (
    .clk(clk), .rst_n(rst_n), .start(start), .mask(mask), .to_regs(to_regs),
    .long_sz(long_sz), .mode(mode), .base_addr(base_addr), .busy(busy), .done(done),
    .wb_en(wb_en), .final_addr(final_addr), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack));

  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = mem[mem_addr[7:1]];

  always @(posedge clk) if (rf_we) rf[rf_waddr] = rf_wdata;

  always @(negedge clk) begin
    if (!rst_n) mem_ack = 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack = 1'b1;
      n_acks++;
      if (mem_we) mem[mem_addr[7:1]] = mem_wdata;
    end else mem_ack = 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic run_op(input logic [15:0] m, input bit ld, input bit lg, input logic [1:0] md,
                        input logic [31:0] base, input int seed, input bit fill_abab, input bit intr);
    int n, w, kd, k, sz;
    logic [31:0] a, ewb, efin, got_fin;
    bit got_wb, pre, ok;
    int bad_i;
    logic [31:0] bad_a, bad_e;
    sz = lg ? 4 : 2;
    pre = (md == 2'd1);
    for (int r = 0; r < 16; r++) rf[r] = 32'h9E3779B9 * (r + 1) + 32'h01010101 * seed;
    for (int i = 0; i < 128; i++) mem[i] = fill_abab ? 16'hABAB : 16'(i * 16'h2F1D + seed * 16'h0457 + 16'h8001);
    for (int r = 0; r < 16; r++) exp_rf[r] = rf[r];
    for (int i = 0; i < 128; i++) exp_mem[i] = mem[i];
    n = 0;
    for (int b = 0; b < 16; b++) if (m[b]) begin
      int r;
      r = pre ? 15 - b : b;
      a = pre ? base - 32'((n + 1) * sz) : base + 32'(n * sz);
      if (ld) exp_rf[r] = lg ? {mem[a[7:1]], mem[a[7:1] + 7'd1]} : {{16{mem[a[7:1]][15]}}, mem[a[7:1]]};
      else if (lg) begin
        exp_mem[a[7:1]] = rf[r][31:16];
        exp_mem[a[7:1] + 7'd1] = rf[r][15:0];
      end else exp_mem[a[7:1]] = rf[r][15:0];
      n++;
    end
    w = n * (lg ? 2 : 1);
    efin = pre ? base - 32'(n * sz) : base + 32'(n * sz);
    ewb = (n != 0 && (md == 2'd1 || md == 2'd2)) ? 1 : 0;
    n_acks = 0;
    mask = m; to_regs = ld; long_sz = lg; mode = md; base_addr = base; start = 1'b1;
    @(negedge clk); start = 1'b0;
    kd = -1; k = 0; got_wb = 0; got_fin = '0;
    while (k < 200) begin
      if (intr && k == 2) begin start = 1'b1; mask = 16'hFFFF; mode = 2'd1; end
      if (intr && k == 3) start = 1'b0;
      if (done) begin kd = k; got_wb = wb_en; got_fin = final_addr; break; end
      @(negedge clk); k++;
    end
    @(negedge clk);
    chk(kd == ((n == 0) ? 1 : 2 * w - 1), "R7 R8 done cycle", 32'(kd), 32'((n == 0) ? 1 : 2 * w - 1));
    chk(!done, "R7 done single pulse", {31'd0, done}, 32'd0);
    chk(n_acks == w, "R2 R8 bus word count", 32'(n_acks), 32'(w));
    chk(got_wb == ewb[0], "R6 R8 writeback enable", {31'd0, got_wb}, ewb);
    if (ewb[0]) chk(got_fin == efin, "R6 final address", got_fin, efin);
    ok = 1; bad_i = 0; bad_a = '0; bad_e = '0;
    for (int i = 0; i < 128; i++) if (ok && mem[i] !== exp_mem[i]) begin
      ok = 0; bad_i = i; bad_a = {16'd0, mem[i]}; bad_e = {16'd0, exp_mem[i]};
    end
    chk(ok, $sformatf("R1 R2 R4 R5 memory word %0d mask=%h md=%0d lg=%0d ld=%0d", bad_i, m, md, lg, ld), bad_a, bad_e);
    ok = 1; bad_i = 0;
    for (int r = 0; r < 16; r++) if (ok && rf[r] !== exp_rf[r]) begin
      ok = 0; bad_i = r; bad_a = rf[r]; bad_e = exp_rf[r];
    end
    chk(ok, $sformatf("R1 R3 R4 R5 register %0d mask=%h md=%0d lg=%0d ld=%0d", bad_i, m, md, lg, ld), bad_a, bad_e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R7 watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [15:0] masks [12];
    logic [15:0] lf;
    masks[0] = 16'h0000; masks[1] = 16'h0001; masks[2] = 16'h8000; masks[3] = 16'hFFFF;
    masks[4] = 16'h00FF; masks[5] = 16'hFF00; masks[6] = 16'h5555; masks[7] = 16'hAAAA;
    lf = 16'hACE1;
    for (int i = 8; i < 12; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      masks[i] = lf;
    end
    repeat (4) @(negedge clk);
    chk(!busy && !done && !mem_req && !rf_we && !wb_en, "R7 R8 reset state",
        {27'd0, busy, done, mem_req, rf_we, wb_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int mi = 0; mi < 12; mi++)
      for (int md = 0; md < 3; md++)
        for (int lg = 0; lg < 2; lg++)
          for (int ld = 0; ld < 2; ld++)
            run_op(masks[mi], ld[0], lg[0], 2'(md), (md == 1) ? 32'h000100E0 : 32'h00010020,
                   mi * 7 + md * 3 + lg + ld, 1'b0, 1'b0);
    run_op(16'hFFFF, 1'b1, 1'b0, 2'd2, 32'h00010020, 5, 1'b1, 1'b0);
    chk(rf[9] == 32'hFFFFABAB && rf[2] == 32'hFFFFABAB, "R3 0xABAB sign extension", rf[9], 32'hFFFFABAB);
    run_op(16'h0F0F, 1'b0, 1'b1, 2'd2, 32'h00010020, 9, 1'b0, 1'b1);
    run_op(16'h0000, 1'b0, 1'b0, 2'd1, 32'h000100E0, 11, 1'b0, 1'b1);
    summary();
  end
endmodule